// File: doc/BRIEF.md
# Timed Control Command Sequencer

This block consumes a stream of 32-bit control words, one command packet at a time, and plays the packet's register operations onto a simple write bus at a chosen moment. A free-running 32-bit tick counter advances once per master clock cycle and serves as the only notion of time. It does not depend on any rate setting of the sample paths. Each packet names the tick at which its operations begin. The block stalls its input until that tick arrives, then issues the operations in order. The all-ones time value means "run now".

Two kinds of operation are understood. A full write replaces a whole register. A masked write changes only the bits selected by a mask, and it needs no bus read-back, because the block keeps a shadow copy of every register. After the last operation the block returns a two-word reply. The first word says that this is a control reply and carries an error flag. The second word is the tick count at which the packet finished. The time word is never used to signal errors.

Top module: `timed_cmd_seq`

## Requirements
- R1: While reset is high and in the cycle after it falls, in_ready is 1, rpl_valid is 0 and bus_we is 0; time_now is 0 during reset.
- R2: time_now rises by exactly one on every clock edge out of reset (modulo 2^32).
- R3: The first word of a packet holds a kind code in bits [31:30] (00 data in, 01 data out, 10 control in, 11 control out). A packet of any kind other than 11 is consumed up to its in_last word with no bus write, no reply and no change to any register.
- R4: The second word is the start tick T. The first operation word is not accepted before the counter has reached T under wrap-safe comparison (time_now − T read as signed ≥ 0); when T lies in the future it is accepted exactly when time_now = T+1.
- R5: T = 0xFFFFFFFF, or a T already in the past, releases the wait at once: the first operation word is accepted two cycles after the start tick word.
- R6: An operation word has opcode in bits [31:24], length in [23:16], must-be-zero bits in [15:10] and register number in [9:0]. Opcode 0x01 with length 2, followed by one value word, overwrites the register and gives one bus_we pulse in the next cycle with that address and value.
- R7: Opcode 0x02 with length 6, followed by a mask word and a value word, drives bus_wdata = (old AND NOT mask) OR (value AND mask) and stores that result, with no read on the bus.
- R8: Nonzero must-be-zero bits [15:10] set the error flag and suppress that operation's write; its words are still consumed, and later operations in the packet still run.
- R9: An unknown opcode, or a known opcode with the wrong length, sets the error flag, and the remainder of the packet is discarded without writes.
- R10: in_last arriving before an operation is complete sets the error flag and causes no write for that operation.
- R11: Each control-out packet yields exactly two rpl_valid cycles. The first is 0x80000000 with bit 0 set to the error flag. The second is time_now in the cycle the packet's last word was accepted, or in the cycle the wait released for a packet with no operations. in_ready is 0 while rpl_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 32 | Command word |
| in_last | input | 1 | Marks the final word of a packet |
| bus_we | output | 1 | One-cycle register write strobe |
| bus_addr | output | 10 | Register number being written |
| bus_wdata | output | 32 | Full new register value |
| rpl_valid | output | 1 | Reply word present |
| rpl_data | output | 32 | Reply header, then finish tick |
| time_now | output | 32 | Master tick counter |

## Verification
The final write of a packet and the first reply word land in the same cycle. When the value word that closes a packet carries in_last, the bus strobe and the reply header both appear one edge later. The finish tick is captured on that same edge. The bench ends several packets this way and keeps writes and replies in separate expected queues. Its monitor checks the write and the reply header in one sampling slot, and it compares the finish tick with the counter value that the driver saw when the closing word was taken.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    localparam int TICK_W = 32;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        KIND_DATA_IN   = 2'b00,
        KIND_DATA_OUT  = 2'b01,
        KIND_CTRL_IN   = 2'b10,
        KIND_CTRL_OUT  = 2'b11
    } pkt_kind_e;

    localparam logic [7:0] OPC_WRITE  = 8'h01;
    localparam logic [7:0] OPC_MWRITE = 8'h02;
    localparam logic [7:0] LEN_WRITE  = 8'd2;
    localparam logic [7:0] LEN_MWRITE = 8'd6;

    localparam logic [TICK_W-1:0] TICK_NOW = '1;

    typedef enum logic [3:0] {
        ST_HDR,
        ST_TIME,
        ST_WAIT,
        ST_OP,
        ST_MASK,
        ST_VAL,
        ST_DROP,
        ST_RPL_HDR,
        ST_RPL_TICK
    } seq_state_e;

    // True once the counter is at or beyond the start tick (wrap-safe),
    // or when the start tick is the immediate code.
    function automatic logic tick_reached(input logic [TICK_W-1:0] now,
                                          input logic [TICK_W-1:0] start);
        logic [TICK_W-1:0] diff;
        diff = now - start;
        return (start == TICK_NOW) || !diff[TICK_W-1];
    endfunction

    function automatic logic [WORD_W-1:0] merge_bits(input logic [WORD_W-1:0] old,
                                                     input logic [WORD_W-1:0] mask,
                                                     input logic [WORD_W-1:0] value);
        return (old & ~mask) | (value & mask);
    endfunction

    function automatic logic [WORD_W-1:0] reply_header(input logic err);
        return {KIND_CTRL_IN, {(WORD_W-3){1'b0}}, err};
    endfunction

endpackage

// File: rtl/tseq_timebase.sv
module tseq_timebase #(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/tseq_shadow.sv
module tseq_shadow #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic [WORD_W-1:0] wr_value,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata
);
    import tseq_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] merged;

    assign merged = merge_bits(mem[wr_addr], wr_mask, wr_value);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else begin
            bus_we <= wr_en;
            if (wr_en) begin
                mem[wr_addr] <= merged;
                bus_addr     <= wr_addr;
                bus_wdata    <= merged;
            end
        end
    end
endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl #(
    parameter int WORD_W = 32,
    parameter int TICK_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TICK_W-1:0] now,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_mask,
    output logic [WORD_W-1:0] wr_value,
    output logic              rpl_valid,
    output logic [WORD_W-1:0] rpl_data,
    output logic              waiting,
    output logic [TICK_W-1:0] start_tick
);
    import tseq_pkg::*;

    localparam int MBZ_LO = ADDR_W;
    localparam int MBZ_HI = 15;

    seq_state_e        state;
    logic [TICK_W-1:0] ts_q;
    logic [TICK_W-1:0] fin_q;
    logic              err_q;
    logic              empty_q;
    logic              ctrl_pkt_q;
    logic              masked_q;
    logic              mbz_bad_q;
    logic [ADDR_W-1:0] reg_q;
    logic [WORD_W-1:0] mask_q;

    logic       acc;
    logic [7:0] opc_in;
    logic [7:0] len_in;
    logic       is_write_in;
    logic       is_mwrite_in;
    logic       mbz_bad_in;

    assign opc_in       = in_data[31:24];
    assign len_in       = in_data[23:16];
    assign is_write_in  = (opc_in == OPC_WRITE)  && (len_in == LEN_WRITE);
    assign is_mwrite_in = (opc_in == OPC_MWRITE) && (len_in == LEN_MWRITE);
    assign mbz_bad_in   = (in_data[MBZ_HI:MBZ_LO] != '0);

    always_comb begin
        case (state)
            ST_HDR, ST_TIME, ST_OP, ST_MASK, ST_VAL, ST_DROP: in_ready = 1'b1;
            default:                                          in_ready = 1'b0;
        endcase
    end

    assign acc = in_valid && in_ready;

    assign wr_en    = acc && (state == ST_VAL) && !mbz_bad_q;
    assign wr_addr  = reg_q;
    assign wr_mask  = masked_q ? mask_q : '1;
    assign wr_value = in_data;

    assign rpl_valid  = (state == ST_RPL_HDR) || (state == ST_RPL_TICK);
    assign rpl_data   = (state == ST_RPL_HDR) ? reply_header(err_q) : fin_q;
    assign waiting    = (state == ST_WAIT);
    assign start_tick = ts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HDR;
            ts_q       <= '0;
            fin_q      <= '0;
            err_q      <= 1'b0;
            empty_q    <= 1'b0;
            ctrl_pkt_q <= 1'b0;
            masked_q   <= 1'b0;
            mbz_bad_q  <= 1'b0;
            reg_q      <= '0;
            mask_q     <= '0;
        end else begin
            case (state)
                ST_HDR: if (acc && !in_last) begin
                    err_q <= 1'b0;
                    if (pkt_kind_e'(in_data[31:30]) == KIND_CTRL_OUT) begin
                        ctrl_pkt_q <= 1'b1;
                        state      <= ST_TIME;
                    end else begin
                        ctrl_pkt_q <= 1'b0;
                        state      <= ST_DROP;
                    end
                end
                ST_TIME: if (acc) begin
                    ts_q    <= in_data;
                    empty_q <= in_last;
                    state   <= ST_WAIT;
                end
                ST_WAIT: if (tick_reached(now, ts_q)) begin
                    if (empty_q) begin
                        fin_q <= now;
                        state <= ST_RPL_HDR;
                    end else begin
                        state <= ST_OP;
                    end
                end
                ST_OP: if (acc) begin
                    reg_q     <= in_data[ADDR_W-1:0];
                    masked_q  <= is_mwrite_in;
                    mbz_bad_q <= mbz_bad_in;
                    if (!(is_write_in || is_mwrite_in)) begin
                        err_q <= 1'b1;
                        if (in_last) begin
                            fin_q <= now;
                            state <= ST_RPL_HDR;
                        end else begin
                            state <= ST_DROP;
                        end
                    end else if (in_last) begin
                        err_q <= 1'b1;
                        fin_q <= now;
                        state <= ST_RPL_HDR;
                    end else begin
                        if (mbz_bad_in) err_q <= 1'b1;
                        state <= is_mwrite_in ? ST_MASK : ST_VAL;
                    end
                end
                ST_MASK: if (acc) begin
                    mask_q <= in_data;
                    if (in_last) begin
                        err_q <= 1'b1;
                        fin_q <= now;
                        state <= ST_RPL_HDR;
                    end else begin
                        state <= ST_VAL;
                    end
                end
                ST_VAL: if (acc) begin
                    if (in_last) begin
                        fin_q <= now;
                        state <= ST_RPL_HDR;
                    end else begin
                        state <= ST_OP;
                    end
                end
                ST_DROP: if (acc && in_last) begin
                    if (ctrl_pkt_q) begin
                        fin_q <= now;
                        state <= ST_RPL_HDR;
                    end else begin
                        state <= ST_HDR;
                    end
                end
                ST_RPL_HDR:  state <= ST_RPL_TICK;
                ST_RPL_TICK: state <= ST_HDR;
                default:     state <= ST_HDR;
            endcase
        end
    end
endmodule

// File: rtl/timed_cmd_seq.sv
module timed_cmd_seq #(
    parameter int WORD_W = 32,
    parameter int TICK_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_last,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              rpl_valid,
    output logic [WORD_W-1:0] rpl_data,
    output logic [TICK_W-1:0] time_now
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_mask;
    logic [WORD_W-1:0] wr_value;
    logic              seq_waiting;
    logic [TICK_W-1:0] seq_ts;

    tseq_timebase #(.TICK_W(TICK_W)) u_timebase (
        .clk   (clk),
        .rst   (rst),
        .count (time_now)
    );

    tseq_ctrl #(.WORD_W(WORD_W), .TICK_W(TICK_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .now        (time_now),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_mask    (wr_mask),
        .wr_value   (wr_value),
        .rpl_valid  (rpl_valid),
        .rpl_data   (rpl_data),
        .waiting    (seq_waiting),
        .start_tick (seq_ts)
    );

    tseq_shadow #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_mask   (wr_mask),
        .wr_value  (wr_value),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );
endmodule

// File: rtl/timed_cmd_seq_chk.sv
module timed_cmd_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        bus_we,
    input logic        rpl_valid,
    input logic [31:0] time_now,
    input logic        seq_waiting,
    input logic [31:0] seq_ts
);
    // R1: idle outputs in the first cycle after reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !rpl_valid && !bus_we));

    // R2: counter steps by one per edge
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (time_now == $past(time_now) + 32'd1));

    // R4: wait only ends once the start tick is reached
    a_r4_no_early_release: assert property (@(posedge clk) disable iff (rst)
        ($past(seq_waiting) && !seq_waiting) |->
        (($past(seq_ts) == 32'hFFFF_FFFF) ||
         (($past(time_now) - $past(seq_ts)) < 32'h8000_0000)));

    // R5: immediate code never waits more than one cycle
    a_r5_now_releases: assert property (@(posedge clk) disable iff (rst)
        (seq_waiting && seq_ts == 32'hFFFF_FFFF) |=> !seq_waiting);

    // R6: each operation produces a single-cycle strobe
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> !bus_we);

    // R11: reply is exactly two words
    a_r11_reply_second: assert property (@(posedge clk) disable iff (rst)
        $rose(rpl_valid) |=> rpl_valid);
    a_r11_reply_ends: assert property (@(posedge clk) disable iff (rst)
        (rpl_valid && $past(rpl_valid)) |=> !rpl_valid);
    a_r11_no_input_in_reply: assert property (@(posedge clk) disable iff (rst)
        rpl_valid |-> !in_ready);
endmodule

bind timed_cmd_seq timed_cmd_seq_chk u_chk (.*);

// File: tb/timed_cmd_seq_bench.sv
module timed_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        bus_we;
    logic [9:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        rpl_valid;
    logic [31:0] rpl_data;
    logic [31:0] time_now;

    int total = 0;
    int bad = 0;
    int events = 0;
    bit done = 0;

    typedef struct { logic [9:0] addr; logic [31:0] data; string req; } wr_item_t;
    typedef struct { logic [31:0] data; string req; } rp_item_t;
    wr_item_t wq[$];
    rp_item_t rq[$];
    logic [31:0] model [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    timed_cmd_seq u_timed_cmd_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rpl_valid(rpl_valid),
        .rpl_data(rpl_data), .time_now(time_now)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr(input logic [1:0] kind);
        return {kind, 30'b0};
    endfunction

    function automatic logic [31:0] opw(input logic [7:0] opc, input logic [7:0] len,
                                        input logic [5:0] mbz, input logic [9:0] r);
        return {opc, len, mbz, r};
    endfunction

    task automatic exp_write(input logic [9:0] a, input logic [31:0] mask,
                             input logic [31:0] val, input string req);
        wr_item_t it;
        model[a] = (model[a] & ~mask) | (val & mask);
        it.addr = a; it.data = model[a]; it.req = req;
        wq.push_back(it);
    endtask

    task automatic exp_reply(input bit err, input logic [31:0] fin, input string req);
        rp_item_t it;
        it.data = err ? 32'h8000_0001 : 32'h8000_0000; it.req = req;
        rq.push_back(it);
        it.data = fin;
        rq.push_back(it);
    endtask

    // Driver: returns accept times of the start tick word, the first
    // operation word and the last word.
    task automatic send_pkt(input logic [31:0] w[$], output logic [31:0] t_ts,
                            output logic [31:0] t_op, output logic [31:0] t_last);
        t_ts = '0; t_op = '0; t_last = '0;
        for (int i = 0; i < w.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = w[i];
            in_last  = (i == w.size() - 1);
            while (!in_ready) @(negedge clk);
            if (i == 1) t_ts = time_now;
            if (i == 2) t_op = time_now;
            t_last = time_now;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // Monitor: scoreboard compare of writes and reply words
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_we) begin
                events++;
                if (wq.size() == 0) check(1'b0, "R3 unexpected write", {22'b0, bus_addr}, 32'h0);
                else begin
                    wr_item_t it;
                    it = wq.pop_front();
                    check(bus_addr == it.addr, it.req, {22'b0, bus_addr}, {22'b0, it.addr});
                    check(bus_wdata == it.data, it.req, bus_wdata, it.data);
                end
            end
            if (rpl_valid) begin
                events++;
                check(!in_ready, "R11 ready low in reply", {31'b0, in_ready}, 32'h0);
                if (rq.size() == 0) check(1'b0, "R3 unexpected reply", rpl_data, 32'h0);
                else begin
                    rp_item_t it;
                    it = rq.pop_front();
                    check(rpl_data == it.data, it.req, rpl_data, it.data);
                end
            end
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

    initial begin
        logic [31:0] pk[$];
        logic [31:0] t_ts, t_op, t_last, ts, t0;
        int ev0;
        for (int i = 0; i < 1024; i++) model[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready", {31'b0, in_ready}, 32'h1);
        check(rpl_valid == 1'b0, "R1 rpl_valid", {31'b0, rpl_valid}, 32'h0);
        check(bus_we == 1'b0, "R1 bus_we", {31'b0, bus_we}, 32'h0);
        check(time_now == 32'h0, "R1 time_now", time_now, 32'h0);
        rst = 1'b0;

        // R2: counter rate
        @(negedge clk);
        t0 = time_now;
        repeat (10) @(negedge clk);
        check(time_now == t0 + 32'd10, "R2 tick rate", time_now, t0 + 32'd10);

        // R6 + R5: plain write with immediate code
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h01, 8'd2, 6'd0, 10'd5), 32'hA5A5_0001};
        exp_write(10'd5, '1, 32'hA5A5_0001, "R6 plain write");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply plain");
        check(t_op == t_ts + 32'd2, "R5 now start", t_op, t_ts + 32'd2);
        settle();

        // R7: masked write keeps unmasked bits
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h02, 8'd6, 6'd0, 10'd5),
               32'h0000_FFFF, 32'h1234_5678};
        exp_write(10'd5, 32'h0000_FFFF, 32'h1234_5678, "R7 masked write");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply masked");
        settle();

        // R4: future start tick
        ts = time_now + 32'd50;
        pk = '{hdr(2'b11), ts, opw(8'h01, 8'd2, 6'd0, 10'd7), 32'hCAFE_0007};
        exp_write(10'd7, '1, 32'hCAFE_0007, "R6 timed write");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply timed");
        check(t_op == ts + 32'd1, "R4 start at tick", t_op, ts + 32'd1);
        settle();

        // R5: start tick already past
        ts = time_now - 32'd100;
        pk = '{hdr(2'b11), ts, opw(8'h01, 8'd2, 6'd0, 10'd8), 32'h0000_0008};
        exp_write(10'd8, '1, 32'h0000_0008, "R6 past write");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply past");
        check(t_op == t_ts + 32'd2, "R5 past start", t_op, t_ts + 32'd2);
        settle();

        // R3: non-control-out kinds are ignored entirely
        for (int k = 0; k < 3; k++) begin
            ev0 = events;
            pk = '{hdr(k[1:0]), 32'hFFFF_FFFF, opw(8'h01, 8'd2, 6'd0, 10'd5), 32'hDEAD_BEEF};
            send_pkt(pk, t_ts, t_op, t_last);
            settle();
            check(events == ev0, "R3 ignored kind", events, ev0);
        end
        // R3: bring out reg 5 with a zero-mask write; value must be unchanged
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h02, 8'd6, 6'd0, 10'd5), 32'h0, 32'hFFFF_FFFF};
        exp_write(10'd5, 32'h0, 32'hFFFF_FFFF, "R3 reg untouched");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply readout");
        settle();

        // R8: nonzero mbz bits skip that write, later op runs, error set
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h01, 8'd2, 6'd4, 10'd9), 32'h9999_9999,
               opw(8'h01, 8'd2, 6'd0, 10'd10), 32'h1010_1010};
        exp_write(10'd10, '1, 32'h1010_1010, "R8 later op runs");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b1, t_last, "R8 error reply");
        settle();
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h02, 8'd6, 6'd0, 10'd9), 32'h0, 32'h1};
        exp_write(10'd9, 32'h0, 32'h1, "R8 reg 9 unchanged");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply readout 9");
        settle();

        // R9: unknown opcode discards rest of packet
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h07, 8'd2, 6'd0, 10'd11), 32'h1,
               opw(8'h01, 8'd2, 6'd0, 10'd11), 32'h1111_1111};
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b1, t_last, "R9 unknown opcode");
        settle();
        // R9: wrong length
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h01, 8'd3, 6'd0, 10'd11), 32'h2};
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b1, t_last, "R9 bad length");
        settle();

        // R10: truncated masked write
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h02, 8'd6, 6'd0, 10'd11), 32'hFFFF_FFFF};
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b1, t_last, "R10 truncated");
        settle();
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h02, 8'd6, 6'd0, 10'd11), 32'h0, 32'h0};
        exp_write(10'd11, 32'h0, 32'h0, "R10 reg 11 unchanged");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply readout 11");
        settle();

        // R11: empty packets, finish tick = release tick
        ts = time_now + 32'd30;
        pk = '{hdr(2'b11), ts};
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, ts, "R11 empty future");
        settle();
        settle();
        pk = '{hdr(2'b11), 32'hFFFF_FFFF};
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_ts + 32'd1, "R11 empty now");
        settle();

        // R7: write then masked write to the same register in one packet
        pk = '{hdr(2'b11), 32'hFFFF_FFFF, opw(8'h01, 8'd2, 6'd0, 10'd1023), 32'hF0F0_F0F0,
               opw(8'h02, 8'd6, 6'd0, 10'd1023), 32'hFF00_0000, 32'h0A00_0000};
        exp_write(10'd1023, '1, 32'hF0F0_F0F0, "R6 top register");
        exp_write(10'd1023, 32'hFF00_0000, 32'h0A00_0000, "R7 back to back");
        send_pkt(pk, t_ts, t_op, t_last);
        exp_reply(1'b0, t_last, "R11 reply pair");
        settle();

        check(wq.size() == 0, "R6 writes drained", wq.size(), 0);
        check(rq.size() == 0, "R11 replies drained", rq.size(), 0);
        done = 1;
        summary();
    end
endmodule